// File: doc/BRIEF.md
# Coprocessor instruction issue acceptor

This block sits on the coprocessor side of a tightly coupled offload port. A host core presents a 32-bit instruction with a hart id and an instruction id on a valid/ready issue channel. In the same cycle, the block decodes the instruction against two custom R4-format operations and answers combinationally. The answer carries an accept bit, destination write flags (single register or even/odd pair), one read flag per source operand, and a flag that says whether extension status will be written.

Accepted instructions go into a small slot store. Source operands reach the block on a register channel, in one of two modes chosen by a parameter. In joint mode the operands arrive alongside the issue request, and the issue and register handshakes are one and the same. In split mode the operands arrive later as a one-cycle pulse tagged with id and hart, and these pulses may come in any order.

An entry leaves on the output valid/ready stream only once every operand it requested has been captured. While the output is stalled, the presented entry does not change. The block has no other buffering or flow control.

Top module: `xif_issue_acceptor`

## Requirements
- R1: After reset the slot store is empty and `out_valid` is 0.
- R2: An instruction whose bits [6:0] are not 7'b0001011, or whose bits [26:25] are 2'b10 or 2'b11, is rejected. A rejected instruction gets `iss_accept`=0 with `iss_wb`, `iss_rdreq` and `iss_ecswr` all 0, and nothing is queued.
- R3: Custom-0 with bits [26:25]=2'b00 is accepted with `iss_wb`=2'b01 (single destination), `iss_rdreq`=3'b111 (bit k is source k+1, with rs1 at [19:15], rs2 at [24:20] and rs3 at [31:27]) and `iss_ecswr`=0.
- R4: Custom-0 with bits [26:25]=2'b01 writes a register pair: `iss_wb`=2'b11, `iss_rdreq`=3'b011, `iss_ecswr`=1. It is accepted only when dual write is enabled and the destination field [11:7] is even; an odd destination is rejected. Bit 1 of `iss_wb` is never set without bit 0.
- R5: The response is a function of the current request only. With `iss_valid` low, `iss_accept` is 0. A request that changes or drops before ready has no effect.
- R6: In joint mode, `reg_ready` equals `iss_ready`. Ready stays low until every `reg_opvld` bit that the decoded instruction reads is 1. Bits for sources it does not read are ignored.
- R7: In split mode, `iss_ready` and `reg_ready` are 1. A `reg_valid` pulse fills only the pending entry whose id and hart both match it.
- R8: When all slots are occupied, a recognised instruction is answered with ready=1 and `iss_accept`=0, which is a rejection.
- R9: The output is valid/ready. While `out_valid`=1 and `out_ready`=0, the presented entry stays unchanged on the next cycle.
- R10: Only entries with all requested operands are released. Among those, the lowest slot goes first, so in split mode the release order follows operand arrival rather than issue order.
- R11: `out_ops` carries source k+1 at bits [32k+31:32k]. Positions the instruction did not request read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Issue request ready |
| iss_instr | input | 32 | Offered instruction |
| iss_hart | input | HART_W | Hart of the offered instruction |
| iss_id | input | ID_W | Instruction id |
| iss_accept | output | 1 | Instruction taken by the coprocessor |
| iss_wb | output | DUAL_WR+1 | Destination write flags |
| iss_rdreq | output | 3 | Source read flags |
| iss_ecswr | output | 1 | Extension status will be written |
| reg_valid | input | 1 | Operand transfer valid |
| reg_ready | output | 1 | Operand transfer ready |
| reg_hart | input | HART_W | Hart tag of operands |
| reg_id | input | ID_W | Id tag of operands (split mode) |
| reg_ops | input | 3*XLEN | Source operands, source 1 lowest |
| reg_opvld | input | 3 | Per-source operand valid (joint mode) |
| out_valid | output | 1 | Completed entry available |
| out_ready | input | 1 | Downstream takes the entry |
| out_id | output | ID_W | Entry id |
| out_hart | output | HART_W | Entry hart |
| out_instr | output | 32 | Entry instruction |
| out_ops | output | 3*XLEN | Entry operands |

## Verification
The hardest situation to reach is a release order that differs from the issue order while a wrongly tagged operand pulse is in flight. It needs two split-mode entries pending at once. The bench gets there by issuing two ids back to back, then sending a pulse with the right id but the wrong hart, then filling the younger entry first. It then checks that the younger entry leaves before the older one. Filling every slot while the output is stalled shows both the structural-hazard rejection and the stability of the held entry.

// File: rtl/xif_acc_pkg.sv
package xif_acc_pkg;
  localparam int NUM_SRC = 3;
  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

  typedef enum logic [1:0] {
    FN_TRIPLE = 2'b00,
    FN_PAIRWR = 2'b01
  } fn_sel_e;

  typedef struct packed {
    logic                known;
    logic [1:0]          wb;
    logic [NUM_SRC-1:0]  rdreq;
    logic                ecswr;
  } dec_t;
endpackage

// File: rtl/xif_op_decode.sv
module xif_op_decode
  import xif_acc_pkg::*;
#(
  parameter int DUAL_WR = 1
) (
  input  logic [6:0] opcode,
  input  logic [1:0] funct2,
  input  logic       rd_lsb,
  output dec_t       dec
);
  always_comb begin
    dec = '0;
    if (opcode == OPC_CUSTOM0) begin
      case (funct2)
        FN_TRIPLE: begin
          dec.known = 1'b1;
          dec.wb    = 2'b01;
          dec.rdreq = 3'b111;
        end
        FN_PAIRWR: begin
          if (DUAL_WR != 0 && !rd_lsb) begin
            dec.known = 1'b1;
            dec.wb    = 2'b11;
            dec.rdreq = 3'b011;
            dec.ecswr = 1'b1;
          end
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/xif_pick_first.sv
module xif_pick_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xif_slot_bank.sv
module xif_slot_bank #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int HART_W = 1,
  parameter int XLEN   = 32,
  parameter int NSRC   = 3,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OPW   = NSRC * XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic [HART_W-1:0] alloc_hart,
  input  logic [31:0]       alloc_instr,
  input  logic [NSRC-1:0]   alloc_need,
  input  logic [OPW-1:0]    alloc_ops,
  input  logic              alloc_filled,
  input  logic              fill_en,
  input  logic [ID_W-1:0]   fill_id,
  input  logic [HART_W-1:0] fill_hart,
  input  logic [OPW-1:0]    fill_ops,
  output logic              full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [HART_W-1:0] out_hart,
  output logic [31:0]       out_instr,
  output logic [OPW-1:0]    out_ops
);
  logic [DEPTH-1:0]  vld_q, done_q, fill_hit;
  logic [ID_W-1:0]   id_q    [DEPTH];
  logic [HART_W-1:0] hart_q  [DEPTH];
  logic [31:0]       instr_q [DEPTH];
  logic [NSRC-1:0]   need_q  [DEPTH];
  logic [OPW-1:0]    ops_q   [DEPTH];

  logic [DEPTH-1:0] free_gnt, unused_rdy_gnt;
  logic [IW-1:0]    unused_free_idx, rdy_idx, sel_idx, hold_idx_q;
  logic             any_free, any_rdy, hold_q, pop;

  function automatic logic [OPW-1:0] keep_needed(input logic [NSRC-1:0] need,
                                                 input logic [OPW-1:0] ops);
    logic [OPW-1:0] res;
    res = '0;
    for (int k = 0; k < NSRC; k++)
      if (need[k]) res[k*XLEN +: XLEN] = ops[k*XLEN +: XLEN];
    return res;
  endfunction

  xif_pick_first #(.N(DEPTH)) free_pick_i (
    .req(~vld_q), .gnt(free_gnt), .idx(unused_free_idx), .any(any_free)
  );
  xif_pick_first #(.N(DEPTH)) rdy_pick_i (
    .req(vld_q & done_q), .gnt(unused_rdy_gnt), .idx(rdy_idx), .any(any_rdy)
  );

  assign full      = !any_free;
  assign sel_idx   = hold_q ? hold_idx_q : rdy_idx;
  assign out_valid = hold_q | any_rdy;
  assign pop       = out_valid && out_ready;
  assign out_id    = id_q[sel_idx];
  assign out_hart  = hart_q[sel_idx];
  assign out_instr = instr_q[sel_idx];
  assign out_ops   = ops_q[sel_idx];

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      fill_hit[i] = fill_en && vld_q[i] && !done_q[i] &&
                    id_q[i] == fill_id && hart_q[i] == fill_hart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i]    <= '0;
        hart_q[i]  <= '0;
        instr_q[i] <= '0;
        need_q[i]  <= '0;
        ops_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && sel_idx == IW'(i)) begin
          vld_q[i]  <= 1'b0;
          done_q[i] <= 1'b0;
        end else if (alloc_en && free_gnt[i]) begin
          vld_q[i]   <= 1'b1;
          done_q[i]  <= alloc_filled;
          id_q[i]    <= alloc_id;
          hart_q[i]  <= alloc_hart;
          instr_q[i] <= alloc_instr;
          need_q[i]  <= alloc_need;
          ops_q[i]   <= keep_needed(alloc_need, alloc_ops);
        end else if (fill_hit[i]) begin
          done_q[i] <= 1'b1;
          ops_q[i]  <= keep_needed(need_q[i], fill_ops);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= out_valid && !out_ready;
      hold_idx_q <= sel_idx;
    end
  end

  // R8: nothing is allocated into a full store
  a_r8_no_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);
  // R9: a stalled output holds its entry
  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_ops));
endmodule

// File: rtl/xif_issue_acceptor.sv
module xif_issue_acceptor
  import xif_acc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ID_W    = 4,
  parameter int HART_W  = 1,
  parameter int DEPTH   = 4,
  parameter int SPLIT   = 0,
  parameter int DUAL_WR = 1,
  localparam int WBW    = DUAL_WR + 1,
  localparam int OPW    = NUM_SRC * XLEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  output logic               iss_ready,
  input  logic [31:0]        iss_instr,
  input  logic [HART_W-1:0]  iss_hart,
  input  logic [ID_W-1:0]    iss_id,
  output logic               iss_accept,
  output logic [WBW-1:0]     iss_wb,
  output logic [NUM_SRC-1:0] iss_rdreq,
  output logic               iss_ecswr,
  input  logic               reg_valid,
  output logic               reg_ready,
  input  logic [HART_W-1:0]  reg_hart,
  input  logic [ID_W-1:0]    reg_id,
  input  logic [OPW-1:0]     reg_ops,
  input  logic [NUM_SRC-1:0] reg_opvld,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ID_W-1:0]    out_id,
  output logic [HART_W-1:0]  out_hart,
  output logic [31:0]        out_instr,
  output logic [OPW-1:0]     out_ops
);
  dec_t dec;
  logic full, take, alloc_en, fill_en;
  logic [OPW-1:0] alloc_ops;

  xif_op_decode #(.DUAL_WR(DUAL_WR)) dec_i (
    .opcode(iss_instr[6:0]), .funct2(iss_instr[26:25]),
    .rd_lsb(iss_instr[7]), .dec(dec)
  );

  assign take       = dec.known && !full;
  assign iss_accept = iss_valid && take;
  assign iss_wb     = iss_accept ? dec.wb[WBW-1:0] : '0;
  assign iss_rdreq  = iss_accept ? dec.rdreq : '0;
  assign iss_ecswr  = iss_accept && dec.ecswr;
  assign alloc_en   = iss_valid && iss_ready && take;

  generate
    if (SPLIT == 0) begin : g_joint
      logic ops_ok;
      logic unused_joint;
      assign ops_ok       = (dec.rdreq & ~reg_opvld) == '0;
      assign iss_ready    = !(take && !ops_ok);
      assign reg_ready    = iss_ready;
      assign alloc_ops    = reg_ops;
      assign fill_en      = 1'b0;
      assign unused_joint = ^{reg_valid, reg_id, reg_hart};
      // R6: an accepted joint handshake has every requested operand
      a_r6_joint_ops: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && iss_accept |-> (iss_rdreq & ~reg_opvld) == '0);
    end else begin : g_split
      logic unused_split;
      assign iss_ready    = 1'b1;
      assign reg_ready    = 1'b1;
      assign alloc_ops    = '0;
      assign fill_en      = reg_valid;
      assign unused_split = ^reg_opvld;
    end
    if (WBW == 2) begin : g_pair_chk
      // R4: pair writeback needs bit 0 and an even destination
      a_r4_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept && iss_wb[1] |-> iss_wb[0] && !iss_instr[7]);
    end
  endgenerate

  xif_slot_bank #(
    .DEPTH(DEPTH), .ID_W(ID_W), .HART_W(HART_W), .XLEN(XLEN), .NSRC(NUM_SRC)
  ) bank_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_id(iss_id), .alloc_hart(iss_hart),
    .alloc_instr(iss_instr), .alloc_need(dec.rdreq), .alloc_ops(alloc_ops),
    .alloc_filled(SPLIT == 0),
    .fill_en(fill_en), .fill_id(reg_id), .fill_hart(reg_hart), .fill_ops(reg_ops),
    .full(full),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_hart(out_hart), .out_instr(out_instr), .out_ops(out_ops)
  );

  // R2: a refused handshake carries an all-zero response
  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && !iss_accept |-> iss_wb == '0 && iss_rdreq == '0 && !iss_ecswr);
endmodule

// File: tb/xif_issue_acceptor_tb_top.sv
module xif_issue_acceptor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic        j_iss_valid = 0, j_out_ready = 0, j_reg_valid = 0;
  logic [31:0] j_iss_instr = 0;
  logic [0:0]  j_iss_hart = 0, j_reg_hart = 0;
  logic [3:0]  j_iss_id = 0, j_reg_id = 0;
  logic [95:0] j_reg_ops = 0;
  logic [2:0]  j_reg_opvld = 0;
  logic        j_iss_ready, j_iss_accept, j_iss_ecswr, j_reg_ready, j_out_valid;
  logic [1:0]  j_iss_wb;
  logic [2:0]  j_iss_rdreq;
  logic [3:0]  j_out_id;
  logic [0:0]  j_out_hart;
  logic [31:0] j_out_instr;
  logic [95:0] j_out_ops;

  logic        s_iss_valid = 0, s_out_ready = 0, s_reg_valid = 0;
  logic [31:0] s_iss_instr = 0;
  logic [0:0]  s_iss_hart = 0, s_reg_hart = 0;
  logic [3:0]  s_iss_id = 0, s_reg_id = 0;
  logic [95:0] s_reg_ops = 0;
  logic [2:0]  s_reg_opvld = 0;
  logic        s_iss_ready, s_iss_accept, s_iss_ecswr, s_reg_ready, s_out_valid;
  logic [1:0]  s_iss_wb;
  logic [2:0]  s_iss_rdreq;
  logic [3:0]  s_out_id;
  logic [0:0]  s_out_hart;
  logic [31:0] s_out_instr;
  logic [95:0] s_out_ops;

  xif_issue_acceptor #(.SPLIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(j_iss_valid), .iss_ready(j_iss_ready), .iss_instr(j_iss_instr),
    .iss_hart(j_iss_hart), .iss_id(j_iss_id), .iss_accept(j_iss_accept),
    .iss_wb(j_iss_wb), .iss_rdreq(j_iss_rdreq), .iss_ecswr(j_iss_ecswr),
    .reg_valid(j_reg_valid), .reg_ready(j_reg_ready), .reg_hart(j_reg_hart),
    .reg_id(j_reg_id), .reg_ops(j_reg_ops), .reg_opvld(j_reg_opvld),
    .out_valid(j_out_valid), .out_ready(j_out_ready), .out_id(j_out_id),
    .out_hart(j_out_hart), .out_instr(j_out_instr), .out_ops(j_out_ops)
  );

  xif_issue_acceptor #(.SPLIT(1)) dut_split_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(s_iss_valid), .iss_ready(s_iss_ready), .iss_instr(s_iss_instr),
    .iss_hart(s_iss_hart), .iss_id(s_iss_id), .iss_accept(s_iss_accept),
    .iss_wb(s_iss_wb), .iss_rdreq(s_iss_rdreq), .iss_ecswr(s_iss_ecswr),
    .reg_valid(s_reg_valid), .reg_ready(s_reg_ready), .reg_hart(s_reg_hart),
    .reg_id(s_reg_id), .reg_ops(s_reg_ops), .reg_opvld(s_reg_opvld),
    .out_valid(s_out_valid), .out_ready(s_out_ready), .out_id(s_out_id),
    .out_hart(s_out_hart), .out_instr(s_out_instr), .out_ops(s_out_ops)
  );

  function automatic logic [31:0] mk(input logic [1:0] f2, input logic [4:0] rd,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [4:0] c);
    return {c, f2, b, a, 3'b000, rd, 7'b0001011};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 joint out_valid after reset", 128'(j_out_valid), 0);
    chk("R1 split out_valid after reset", 128'(s_out_valid), 0);
  endtask

  task automatic t_reject();
    @(negedge clk); j_iss_valid = 1; j_iss_instr = 32'h00000033; j_reg_opvld = 0; #1;
    chk("R2 foreign opcode accept", 128'(j_iss_accept), 0);
    chk("R2 foreign opcode ready", 128'(j_iss_ready), 1);
    chk("R2 foreign opcode flags", 128'({j_iss_wb, j_iss_rdreq, j_iss_ecswr}), 0);
    @(negedge clk); j_iss_instr = mk(2'b10, 5'd2, 5'd1, 5'd2, 5'd3); #1;
    chk("R2 unknown funct accept", 128'(j_iss_accept), 0);
    @(negedge clk); j_iss_instr = mk(2'b01, 5'd5, 5'd1, 5'd2, 5'd3); #1;
    chk("R4 odd pair destination accept", 128'(j_iss_accept), 0);
    chk("R4 odd pair destination flags", 128'({j_iss_wb, j_iss_rdreq, j_iss_ecswr}), 0);
    @(negedge clk); j_iss_valid = 0; #1;
    chk("R2 rejected not queued", 128'(j_out_valid), 0);
  endtask

  task automatic t_joint_triple();
    @(negedge clk);
    j_iss_valid = 1; j_iss_id = 4'd3; j_iss_instr = mk(2'b00, 5'd9, 5'd1, 5'd2, 5'd3);
    j_reg_ops = {32'hC0C0C0C0, 32'hB0B0B0B0, 32'hA0A0A0A0}; j_reg_opvld = 3'b000; #1;
    chk("R6 ready withheld no operands", 128'(j_iss_ready), 0);
    chk("R6 register ready follows", 128'(j_reg_ready), 0);
    chk("R3 triple accept", 128'(j_iss_accept), 1);
    chk("R3 triple wb", 128'(j_iss_wb), 128'h1);
    chk("R3 triple rdreq", 128'(j_iss_rdreq), 128'h7);
    chk("R3 triple ecswr", 128'(j_iss_ecswr), 0);
    @(negedge clk); j_reg_opvld = 3'b011; #1;
    chk("R6 ready withheld rs3 missing", 128'(j_iss_ready), 0);
    @(negedge clk); j_reg_opvld = 3'b111; #1;
    chk("R6 ready with all operands", 128'(j_iss_ready), 1);
    chk("R6 register ready with all operands", 128'(j_reg_ready), 1);
    @(negedge clk); j_iss_valid = 0; j_reg_opvld = 0; #1;
    chk("R10 complete entry released", 128'(j_out_valid), 1);
    chk("R10 released id", 128'(j_out_id), 128'h3);
    chk("R11 operand order", 128'(j_out_ops), 128'({32'hC0C0C0C0, 32'hB0B0B0B0, 32'hA0A0A0A0}));
    chk("R10 released instr", 128'(j_out_instr), 128'(mk(2'b00, 5'd9, 5'd1, 5'd2, 5'd3)));
    @(negedge clk); j_out_ready = 1; #1;
    chk("R9 still valid before pop", 128'(j_out_valid), 1);
    @(negedge clk); j_out_ready = 0; #1;
    chk("R9 popped", 128'(j_out_valid), 0);
  endtask

  task automatic t_joint_pair();
    @(negedge clk);
    j_iss_valid = 1; j_iss_id = 4'd4; j_iss_instr = mk(2'b01, 5'd6, 5'd1, 5'd2, 5'd3);
    j_reg_ops = {32'hDDDDDDDD, 32'hBBBBBBBB, 32'hAAAAAAAA}; j_reg_opvld = 3'b011; #1;
    chk("R6 unneeded rs3 ignored", 128'(j_iss_ready), 1);
    chk("R4 pair accept", 128'(j_iss_accept), 1);
    chk("R4 pair wb", 128'(j_iss_wb), 128'h3);
    chk("R4 pair rdreq", 128'(j_iss_rdreq), 128'h3);
    chk("R4 pair ecswr", 128'(j_iss_ecswr), 1);
    @(negedge clk); j_iss_valid = 0; j_reg_opvld = 0; j_out_ready = 1; #1;
    chk("R10 pair released", 128'(j_out_id), 128'h4);
    chk("R11 unrequested rs3 zero", 128'(j_out_ops), 128'({32'h0, 32'hBBBBBBBB, 32'hAAAAAAAA}));
    @(negedge clk); j_out_ready = 0; #1;
    chk("R9 pair popped", 128'(j_out_valid), 0);
  endtask

  task automatic t_retract();
    @(negedge clk);
    j_iss_valid = 1; j_iss_id = 4'd7; j_iss_instr = mk(2'b00, 5'd1, 5'd1, 5'd2, 5'd3);
    j_reg_opvld = 0; #1;
    chk("R5 accept while waiting", 128'(j_iss_accept), 1);
    @(negedge clk); j_iss_hart = 1; j_iss_instr = 32'h00000033; #1;
    chk("R5 changed request response", 128'(j_iss_accept), 0);
    @(negedge clk); j_iss_valid = 0; j_iss_hart = 0; #1;
    chk("R5 no valid no accept", 128'(j_iss_accept), 0);
    chk("R5 retracted not queued", 128'(j_out_valid), 0);
  endtask

  task automatic t_full();
    j_out_ready = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      j_iss_valid = 1; j_iss_id = 4'(8 + k); j_iss_instr = mk(2'b00, 5'(k + 1), 5'd1, 5'd2, 5'd3);
      j_reg_opvld = 3'b111; j_reg_ops = {3{32'(k)}};
    end
    @(negedge clk); j_iss_id = 4'd12; #1;
    chk("R8 full ready", 128'(j_iss_ready), 1);
    chk("R8 full refuses accept", 128'(j_iss_accept), 0);
    chk("R8 full flags zero", 128'(j_iss_wb), 0);
    @(negedge clk); j_iss_valid = 0; j_reg_opvld = 0; #1;
    chk("R9 head valid", 128'(j_out_valid), 1);
    chk("R9 head id", 128'(j_out_id), 128'h8);
    @(negedge clk); #1;
    chk("R9 head held", 128'(j_out_id), 128'h8);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); j_out_ready = 1; #1;
      chk("R10 drain valid", 128'(j_out_valid), 1);
      chk("R10 drain order", 128'(j_out_id), 128'(8 + k));
    end
    @(negedge clk); j_out_ready = 0; #1;
    chk("R10 drained empty", 128'(j_out_valid), 0);
  endtask

  task automatic t_split();
    @(negedge clk);
    s_iss_valid = 1; s_iss_id = 4'd5; s_iss_instr = mk(2'b00, 5'd2, 5'd1, 5'd2, 5'd3); #1;
    chk("R7 split issue ready", 128'(s_iss_ready), 1);
    chk("R7 split register ready", 128'(s_reg_ready), 1);
    chk("R3 split accept", 128'(s_iss_accept), 1);
    @(negedge clk); s_iss_id = 4'd6; s_iss_instr = mk(2'b01, 5'd4, 5'd1, 5'd2, 5'd3); #1;
    chk("R4 split pair accept", 128'(s_iss_accept), 1);
    @(negedge clk); s_iss_valid = 0; #1;
    chk("R10 waits for operands", 128'(s_out_valid), 0);
    @(negedge clk);
    s_reg_valid = 1; s_reg_id = 4'd5; s_reg_hart = 1; s_reg_ops = {3{32'h55555555}};
    @(negedge clk); s_reg_valid = 0; #1;
    chk("R7 wrong hart ignored", 128'(s_out_valid), 0);
    @(negedge clk);
    s_reg_valid = 1; s_reg_id = 4'd6; s_reg_hart = 0;
    s_reg_ops = {32'h33333333, 32'h22222222, 32'h11111111};
    @(negedge clk); s_reg_valid = 0; s_out_ready = 1; #1;
    chk("R10 younger released first", 128'(s_out_valid), 1);
    chk("R10 younger id", 128'(s_out_id), 128'h6);
    chk("R11 split unrequested zero", 128'(s_out_ops), 128'({32'h0, 32'h22222222, 32'h11111111}));
    @(negedge clk);
    s_out_ready = 0; s_reg_valid = 1; s_reg_id = 4'd5; s_reg_hart = 0;
    s_reg_ops = {32'hC3C3C3C3, 32'hC2C2C2C2, 32'hC1C1C1C1}; #1;
    chk("R10 older still incomplete", 128'(s_out_valid), 0);
    @(negedge clk); s_reg_valid = 0; s_out_ready = 1; #1;
    chk("R7 matching operands filled", 128'(s_out_id), 128'h5);
    chk("R11 split operands", 128'(s_out_ops), 128'({32'hC3C3C3C3, 32'hC2C2C2C2, 32'hC1C1C1C1}));
    @(negedge clk); s_out_ready = 0; #1;
    chk("R10 split empty", 128'(s_out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_reject();
    t_joint_triple();
    t_joint_pair();
    t_retract();
    t_full();
    t_split();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule